// File: doc/BRIEF.md
# Period Capture Timer with Selectable Input Synchronizer

This block measures the time between active edges of an external trigger that is not related to the local clock. A free-running up-counter advances once per enabled clock. Each detected trigger edge does two things in a single clock. The capture register takes the value the counter reaches in that clock, and the counter restarts from zero. The captured value is therefore the full number of clocks between two detected edges, and it can never be the reload value.

The trigger first passes through a synchronizer whose depth software selects at run time: no register, one register, or two registers. A change detector follows it and fires on rising edges, falling edges or both. A capture raises a status flag that drives the interrupt output and stays set until software clears it. A capture that arrives while the flag is still set marks a sticky missed-capture bit. Software can also load the counter directly through a small register port. The read port is combinational on the address.

Register map (address on `regAddr`): 0 control, 1 counter (read/write), 2 capture (read only), 3 status (write 1 to clear).

Top module: `period_capture_timer`

## Requirements
- R1: A detected edge loads the capture register with the value the counter reaches in that clock: the current count plus one when `countEn` is high, the current count when it is low, and all ones when the counter is saturated. In the same clock the counter becomes 0, so a capture never returns the reloaded zero.
- R2: Two detected edges that are N enabled clocks apart leave N in the capture register. With a 2 MHz count clock, a 1 ms trigger period reads back as 2000.
- R3: Control bits [1:0] select the synchronizer depth: 0 means no register, 1 means one register, 2 or 3 means two registers. A rising trigger driven before a clock edge shows on `irqOut` 1, 2 or 3 clocks later.
- R4: Control bits [3:2] select the active polarity: 01 rising, 10 falling, 11 both. With 00, trigger edges are ignored: no capture and no status change.
- R5: Status bit 0 is set by a capture and drives `irqOut`. It stays set until status is written with bit 0 equal to 1. Writing 1 to a status bit clears it.
- R6: A capture while status bit 0 is already set sets the sticky status bit 1, and the capture register still takes the new value.
- R7: A write to address 1 loads the counter, and a read of address 1 returns the running count.
- R8: When a counter write and a detected edge fall in the same clock, the edge wins: the counter becomes 0 and the capture takes the pre-write count.
- R9: The counter saturates at all ones instead of wrapping. Reaching all ones by counting sets the sticky status bit 2.
- R10: While `countEn` is low the counter holds its value.
- R11: Synchronous active-low reset clears the counter, the capture register, the control register, all status bits and the synchronizer registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count and register clock |
| rstN | input | 1 | Synchronous reset, active low |
| countEn | input | 1 | Counter advance enable |
| trigIn | input | 1 | Asynchronous trigger input |
| regAddr | input | 2 | Register address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | CNT_W | Register write data |
| regRdData | output | CNT_W | Register read data for `regAddr` |
| irqOut | output | 1 | Capture interrupt (status bit 0) |

## Verification
The bench builds the block with `CNT_W` = 16, down from the default of 32. This makes saturation reachable: the bench preloads a count just below all ones and lets it count a few clocks, then checks both the saturation and the capture taken while saturated. At that width the 2000-clock period still fits easily, next to short periods and edges driven in the same clock as a counter write. The edge-to-interrupt latency is measured separately for each synchronizer depth.

// File: rtl/pct_pkg.sv
package pct_pkg;
  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_COUNT  = 2'd1;
  localparam logic [1:0] ADDR_CAPT   = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

  typedef struct packed {
    logic capture;  // detected edge: capture and reload
    logic load;     // software counter write
  } dpStrobes_t;
endpackage

// File: rtl/pct_input_sync.sv
module pct_input_sync #(
  parameter int MAX_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] syncMode,
  input  logic       trigIn,
  output logic       syncOut
);
  logic [MAX_STAGES:0] chain;
  assign chain[0] = trigIn;

  for (genvar g = 0; g < MAX_STAGES; g++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) chain[g+1] <= 1'b0;
      else       chain[g+1] <= chain[g];
    end
  end

  always_comb begin
    syncOut = chain[MAX_STAGES];
    for (int i = 0; i <= MAX_STAGES; i++)
      if (int'(syncMode) == i) syncOut = chain[i];
  end
endmodule

// File: rtl/pct_ctrl.sv
module pct_ctrl
  import pct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigIn,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [3:0]       wrBits,
  input  logic [CNT_W-1:0] countVal,
  input  logic [CNT_W-1:0] captVal,
  input  logic             ovfHit,
  output dpStrobes_t       strobes,
  output logic [CNT_W-1:0] rdData,
  output logic             irqOut
);
  logic [3:0] cfgQ;
  logic       syncOut, prevQ, riseDet, fallDet, edgePulse;
  logic [2:0] statusQ, clrBits;
  logic       missedSet;

  pct_input_sync #(.MAX_STAGES(2)) sync_i (
    .clk(clk), .rstN(rstN), .syncMode(cfgQ[1:0]),
    .trigIn(trigIn), .syncOut(syncOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ  <= '0;
      prevQ <= 1'b0;
    end else begin
      if (regWrEn && regAddr == ADDR_CTRL) cfgQ <= wrBits;
      prevQ <= syncOut;
    end
  end

  assign riseDet   = syncOut & ~prevQ;
  assign fallDet   = ~syncOut & prevQ;
  assign edgePulse = (cfgQ[2] & riseDet) | (cfgQ[3] & fallDet);

  assign clrBits   = (regWrEn && regAddr == ADDR_STATUS) ? wrBits[2:0] : 3'b000;
  assign missedSet = edgePulse & statusQ[0] & ~clrBits[0];

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else begin
      statusQ[0] <= edgePulse | (statusQ[0] & ~clrBits[0]);
      statusQ[1] <= missedSet | (statusQ[1] & ~clrBits[1]);
      statusQ[2] <= ovfHit    | (statusQ[2] & ~clrBits[2]);
    end
  end

  assign strobes.capture = edgePulse;
  assign strobes.load    = regWrEn && regAddr == ADDR_COUNT;
  assign irqOut          = statusQ[0];

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL:  rdData = {{(CNT_W-4){1'b0}}, cfgQ};
      ADDR_COUNT: rdData = countVal;
      ADDR_CAPT:  rdData = captVal;
      default:    rdData = {{(CNT_W-3){1'b0}}, statusQ};
    endcase
  end

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    irqOut && !(regWrEn && regAddr == ADDR_STATUS && wrBits[0]) |=> irqOut); // R5
  AST_MISSED_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[1] && !(regWrEn && regAddr == ADDR_STATUS && wrBits[1]) |=> statusQ[1]); // R6
  AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    edgePulse && cfgQ[3:2] == 2'b01 |=> !edgePulse || !$stable(cfgQ)); // R4
  AST_NO_SEL_NO_CAPT: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ[3:2] == 2'b00 |-> !strobes.capture); // R4
endmodule

// File: rtl/pct_datapath.sv
module pct_datapath
  import pct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  dpStrobes_t       strobes,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] captVal,
  output logic             ovfHit
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cntQ, capQ, cntNext;

  assign cntNext = (!countEn || cntQ == CNT_MAX) ? cntQ : cntQ + 1'b1;
  assign ovfHit  = countEn && cntQ == CNT_MAX - 1'b1 && !strobes.capture && !strobes.load;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      capQ <= '0;
    end else if (strobes.capture) begin
      capQ <= cntNext;
      cntQ <= '0;
    end else if (strobes.load) begin
      cntQ <= loadVal;
    end else begin
      cntQ <= cntNext;
    end
  end

  assign countVal = cntQ;
  assign captVal  = capQ;

  AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> countVal == '0); // R1
  AST_CAP_PRE_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture && countEn && cntQ != CNT_MAX |=> captVal == $past(cntQ) + 1'b1); // R1
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    cntQ == CNT_MAX && !strobes.capture && !strobes.load |=> cntQ == CNT_MAX); // R9
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !countEn && !strobes.capture && !strobes.load |=> $stable(cntQ)); // R10
endmodule

// File: rtl/period_capture_timer.sv
module period_capture_timer
  import pct_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  logic             trigIn,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [CNT_W-1:0] regWrData,
  output logic [CNT_W-1:0] regRdData,
  output logic             irqOut
);
  dpStrobes_t       strobes;
  logic [CNT_W-1:0] countVal, captVal;
  logic             ovfHit;

  pct_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .wrBits(regWrData[3:0]), .countVal(countVal),
    .captVal(captVal), .ovfHit(ovfHit), .strobes(strobes),
    .rdData(regRdData), .irqOut(irqOut)
  );

  pct_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .countEn(countEn), .strobes(strobes),
    .loadVal(regWrData), .countVal(countVal), .captVal(captVal),
    .ovfHit(ovfHit)
  );
endmodule

// File: tb/period_capture_timer_tb_top.sv
module period_capture_timer_tb_top;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             countEn = 1'b0;
  logic             trigIn = 1'b0;
  logic [1:0]       regAddr = 2'd0;
  logic             regWrEn = 1'b0;
  logic [CNT_W-1:0] regWrData = '0;
  logic [CNT_W-1:0] regRdData;
  logic             irqOut;

  int checks = 0;
  int errors = 0;
  bit monOn = 1'b0;
  bit done = 1'b0;
  int expQ[$];

  always #4 clk = ~clk;

  period_capture_timer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .countEn(countEn), .trigIn(trigIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, int d);
    @(negedge clk);
    regAddr = a; regWrData = CNT_W'(d); regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, output int d);
    regAddr = a;
    #1 d = int'(regRdData);
  endtask

  // driver: raise trigger now, next rise comes p clocks later
  task automatic risePeriod(int p);
    trigIn = 1'b1;
    repeat (2) @(negedge clk);
    trigIn = 1'b0;
    repeat (p - 2) @(negedge clk);
  endtask

  // monitor: pops one expected capture per interrupt
  initial begin
    int v, st, e;
    forever begin
      @(negedge clk);
      if (monOn && irqOut) begin
        regRead(2'd2, v);
        if (expQ.size() == 0) check("R2 unexpected capture", 1, 0);
        else begin
          e = expQ.pop_front();
          if (e >= 0) check("R2 period capture", v, e);
        end
        regRead(2'd3, st);
        check("R6 no missed flag", st, 1);
        regWrData = CNT_W'(st); regWrEn = 1'b1;
        @(negedge clk);
        regWrEn = 1'b0;
      end
    end
  end

  task automatic finishSim();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishSim();
  end

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    regRead(2'd0, v); check("R11 ctrl reset", v, 0);
    regRead(2'd1, v); check("R11 count reset", v, 0);
    regRead(2'd2, v); check("R11 capture reset", v, 0);
    regRead(2'd3, v); check("R11 status reset", v, 0);
    check("R11 irq reset", int'(irqOut), 0);

    // R2 periods through two-register sync, rising edges
    regWrite(2'd0, 4'b0110);
    countEn = 1'b1;
    monOn = 1'b1;
    @(negedge clk);
    expQ.push_back(-1); risePeriod(10);
    expQ.push_back(10); risePeriod(37);
    expQ.push_back(37); risePeriod(2000);
    expQ.push_back(2000); risePeriod(25);
    expQ.push_back(25); risePeriod(20);
    repeat (10) @(negedge clk);
    check("R2 all captures seen", expQ.size(), 0);
    monOn = 1'b0;

    // R3 latency per synchronizer depth
    for (int m = 0; m < 3; m++) begin
      regWrite(2'd0, 4 + m);
      repeat (4) @(negedge clk);
      regWrite(2'd3, 7);
      trigIn = 1'b1;
      n = 0;
      while (!irqOut && n < 10) begin @(negedge clk); n++; end
      check($sformatf("R3 latency mode %0d", m), n, m + 1);
      trigIn = 1'b0;
      repeat (4) @(negedge clk);
      regWrite(2'd3, 7);
    end

    // R6 missed capture, capture still updated
    regWrite(2'd0, 4'b0100);
    regWrite(2'd3, 7);
    @(negedge clk);
    trigIn = 1'b1; @(negedge clk); trigIn = 1'b0;
    repeat (5) @(negedge clk);
    trigIn = 1'b1; @(negedge clk); trigIn = 1'b0;
    regRead(2'd2, v); check("R6 capture updated", v, 6);
    regRead(2'd3, v); check("R6 missed set", v, 3);
    regWrite(2'd3, 1);
    regRead(2'd3, v); check("R5 clear bit0 only", v, 2);
    check("R5 irq cleared", int'(irqOut), 0);
    regWrite(2'd3, 2);
    regRead(2'd3, v); check("R6 missed cleared", v, 0);

    // R4 falling only: rise ignored, fall-to-fall measured
    regWrite(2'd0, 4'b1000);
    @(negedge clk);
    trigIn = 1'b1; repeat (4) @(negedge clk);
    check("R4 rise ignored on falling select", int'(irqOut), 0);
    trigIn = 1'b0; repeat (3) @(negedge clk);
    trigIn = 1'b1; repeat (12) @(negedge clk);
    trigIn = 1'b0; @(negedge clk);
    regRead(2'd2, v); check("R4 falling period", v, 15);
    regWrite(2'd3, 7);

    // R4 both edges: high width
    regWrite(2'd0, 4'b1100);
    @(negedge clk);
    trigIn = 1'b1; repeat (7) @(negedge clk);
    trigIn = 1'b0; @(negedge clk);
    regRead(2'd2, v); check("R4 both edges width", v, 7);
    regWrite(2'd3, 7);

    // R4 no polarity: trigger ignored
    regWrite(2'd0, 4'b0000);
    @(negedge clk);
    trigIn = 1'b1; repeat (3) @(negedge clk);
    trigIn = 1'b0; repeat (3) @(negedge clk);
    regRead(2'd3, v); check("R4 none selected status", v, 0);
    regRead(2'd2, v); check("R4 none selected capture", v, 7);

    // R7 / R10 software write and enable
    countEn = 1'b0;
    regWrite(2'd1, 100);
    regRead(2'd1, v); check("R7 counter write", v, 100);
    repeat (3) @(negedge clk);
    regRead(2'd1, v); check("R10 hold while disabled", v, 100);
    countEn = 1'b1;
    repeat (5) @(negedge clk);
    countEn = 1'b0;
    regRead(2'd1, v); check("R7 count after enable", v, 105);

    // R8 edge beats write in same clock
    regWrite(2'd0, 4'b0100);
    regWrite(2'd1, 77);
    @(negedge clk);
    trigIn = 1'b1; regAddr = 2'd1; regWrData = 16'd500; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; trigIn = 1'b0;
    regRead(2'd1, v); check("R8 counter reloaded to zero", v, 0);
    regRead(2'd2, v); check("R1 capture pre-reload value", v, 77);
    regWrite(2'd3, 7);

    // R9 saturation and overflow flag
    regWrite(2'd1, 16'hFFFC);
    countEn = 1'b1;
    repeat (10) @(negedge clk);
    countEn = 1'b0;
    regRead(2'd1, v); check("R9 saturated count", v, 16'hFFFF);
    regRead(2'd3, v); check("R9 overflow flag", v, 4);
    trigIn = 1'b1; @(negedge clk); trigIn = 1'b0;
    regRead(2'd2, v); check("R1 capture while saturated", v, 16'hFFFF);
    regRead(2'd1, v); check("R1 counter zero after capture", v, 0);

    // R11 reset mid-run
    countEn = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b0; @(negedge clk); rstN = 1'b1; countEn = 1'b0;
    regRead(2'd3, v); check("R11 status after reset", v, 0);
    regRead(2'd2, v); check("R11 capture after reset", v, 0);
    regRead(2'd1, v); check("R11 count after reset", v, 0);
    finishSim();
  end
endmodule